// File: doc/BRIEF.md
# Level-2 Decision Handshake Controller

This block sits between the level-1 trigger path and an external trigger supervisor. It latches a level-1 accept together with its 2-bit buffer number and 8-bit bunch count. It then waits for a decision packet on an input word stream, or gives up after a programmable number of cycles. A programmable number of cycles after the packet ends, it presents one outcome to the supervisor: accept, reject or timeout. It holds that outcome under a request strobe until the supervisor acknowledges, then waits for the acknowledge to fall before it takes a new accept.

Each decision word is stored in a small readout RAM. The RAM has one slot per buffer number, and each slot keeps a word count. The first word of every packet is a header. Its buffer number and bunch count are compared with the values latched from the level-1 accept, and any difference sets a sticky flag. Packets are forwarded whether or not they match. A level-1 accept that arrives while an event is still being handled sets a sticky overrun flag and is discarded.

Top module: `l2_decision_ctrl`

## Requirements
- R1: After reset the strobe, the three outcome lines and both sticky flags are low, and the word count of every buffer reads 0.
- R2: A level-1 accept is taken only while the controller is idle, and it latches the buffer number and bunch count. Decision words presented while idle are ignored: nothing is written and no outcome follows.
- R3: The header is the first decision word: bit 31 = 1 means accept and 0 means reject, bits [1:0] carry the buffer number and bits [15:8] the bunch count. The strobe rises exactly `delay_cfg_i`+1 cycles after the clock edge that takes the last word (`dec_last_i`).
- R4: If no header arrives, the timeout outcome is presented `timeout_cfg_i`+1 cycles after the edge that takes the level-1 accept. A header that arrives in the very cycle the timeout would expire wins, and the event completes normally.
- R5: While the strobe is high exactly one of accept, reject and timeout is high. While the strobe is low all three are low.
- R6: The strobe and outcome stay high and unchanged until `ts_ack_i` is seen high. The strobe then drops on the next cycle, and the controller rearms only after `ts_ack_i` has returned low.
- R7: A header whose buffer number or bunch count differs from the latched values sets `mismatch_o`, which stays set until reset. The outcome is still forwarded.
- R8: A level-1 accept that arrives while the controller is not idle sets `overrun_o`, which stays set until reset. That accept produces no event.
- R9: The words of a packet are written in arrival order, from address 0, into the buffer named by the latched level-1 buffer number. The count equals the number of words, and words beyond DEPTH (16) are dropped while the count saturates at DEPTH.
- R10: A new packet restarts the count of its own buffer. The counts and data of the other buffers are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1a_i | input | 1 | Level-1 accept pulse |
| l1a_buf_i | input | 2 | Buffer number of the accept |
| l1a_bc_i | input | 8 | Bunch count of the accept |
| dec_valid_i | input | 1 | Decision word valid |
| dec_data_i | input | 32 | Decision word (the first word is the header) |
| dec_last_i | input | 1 | Marks the last word of a packet |
| delay_cfg_i | input | 16 | Cycles between packet end and outcome |
| timeout_cfg_i | input | 16 | Cycles to wait for a header |
| ts_ack_i | input | 1 | Acknowledge from the supervisor |
| ts_strobe_o | output | 1 | Outcome request strobe |
| l2_accept_o | output | 1 | Accept outcome |
| l2_reject_o | output | 1 | Reject outcome |
| l2_timeout_o | output | 1 | Timeout outcome |
| mismatch_o | output | 1 | Sticky header mismatch flag |
| overrun_o | output | 1 | Sticky dropped-accept flag |
| rd_buf_i | input | 2 | Readout buffer select |
| rd_addr_i | input | 4 | Readout word address |
| rd_data_o | output | 32 | Readout word |
| rd_count_o | output | 5 | Word count of the selected buffer |

## Verification
The two functions that can coincide are the expiry of the header wait and the arrival of the header itself. The bench counts cycles from the edge that takes the accept and drives the header into exactly the cycle in which the wait counter reaches its limit. It then expects an accept, not a timeout, with the normal delay and a word count of 1 in that buffer. A second coincidence is a level-1 accept while an event is in flight. That case is judged by the overrun flag, by the first accept's values still being the ones compared against the header, and by the absence of any strobe afterwards.

// File: rtl/l2hs_pkg.sv
package l2hs_pkg;
    localparam int BUF_W       = 2;
    localparam int NBUF        = 1 << BUF_W;
    localparam int BC_W        = 8;
    // header field positions, decoded by the checker and sequencer
    localparam int HDR_BUF_LSB = 0;
    localparam int HDR_BC_LSB  = 8;
    localparam int HDR_DEC_BIT = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RECV,
        ST_DELAY,
        ST_SHAKE,
        ST_RELEASE
    } state_e;

    typedef enum logic [1:0] {
        OC_NONE,
        OC_ACCEPT,
        OC_REJECT,
        OC_TIMEOUT
    } outcome_e;
endpackage

// File: rtl/l2hs_sequencer.sv
module l2hs_sequencer
    import l2hs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l1a_i,
    input  logic [BUF_W-1:0] l1a_buf_i,
    input  logic [BC_W-1:0]  l1a_bc_i,
    input  logic             dec_valid_i,
    input  logic             dec_accept_i,
    input  logic             dec_last_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [CNT_W-1:0] timeout_i,
    input  logic             ts_ack_i,
    output logic             strobe_o,
    output logic             accept_o,
    output logic             reject_o,
    output logic             timeout_o,
    output logic             overrun_o,
    output logic             wr_en_o,
    output logic             wr_first_o,
    output logic [BUF_W-1:0] lat_buf_o,
    output logic [BC_W-1:0]  lat_bc_o
);
    typedef struct packed {
        state_e             state;
        outcome_e           outcome;
        logic [CNT_W-1:0]   cnt;
        logic [BUF_W-1:0]   l1_buf;
        logic [BC_W-1:0]    l1_bc;
        logic               overrun;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        wr_en_o    = 1'b0;
        wr_first_o = 1'b0;
        if (l1a_i && seq_q.state != ST_IDLE) begin
            seq_d.overrun = 1'b1;
        end
        case (seq_q.state)
            ST_IDLE: begin
                if (l1a_i) begin
                    seq_d.state  = ST_WAIT;
                    seq_d.cnt    = '0;
                    seq_d.l1_buf = l1a_buf_i;
                    seq_d.l1_bc  = l1a_bc_i;
                end
            end
            ST_WAIT: begin
                if (dec_valid_i) begin
                    wr_en_o       = 1'b1;
                    wr_first_o    = 1'b1;
                    seq_d.outcome = dec_accept_i ? OC_ACCEPT : OC_REJECT;
                    seq_d.cnt     = '0;
                    seq_d.state   = dec_last_i ? ST_DELAY : ST_RECV;
                end else if (seq_q.cnt == timeout_i) begin
                    seq_d.outcome = OC_TIMEOUT;
                    seq_d.state   = ST_SHAKE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_RECV: begin
                if (dec_valid_i) begin
                    wr_en_o = 1'b1;
                    if (dec_last_i) begin
                        seq_d.state = ST_DELAY;
                        seq_d.cnt   = '0;
                    end
                end
            end
            ST_DELAY: begin
                if (seq_q.cnt == delay_i) begin
                    seq_d.state = ST_SHAKE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_SHAKE: begin
                if (ts_ack_i) begin
                    seq_d.state = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (!ts_ack_i) begin
                    seq_d.state   = ST_IDLE;
                    seq_d.outcome = OC_NONE;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, outcome: OC_NONE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign strobe_o  = (seq_q.state == ST_SHAKE);
    assign accept_o  = strobe_o && (seq_q.outcome == OC_ACCEPT);
    assign reject_o  = strobe_o && (seq_q.outcome == OC_REJECT);
    assign timeout_o = strobe_o && (seq_q.outcome == OC_TIMEOUT);
    assign overrun_o = seq_q.overrun;
    assign lat_buf_o = seq_q.l1_buf;
    assign lat_bc_o  = seq_q.l1_bc;

    // R2: an idle accept always opens the header wait
    a_r2_idle_accept_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_IDLE && l1a_i) |=> (seq_q.state == ST_WAIT));
    // R4: a header taken in the wait state never ends in timeout
    a_r4_header_beats_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        wr_first_o |=> (seq_q.outcome != OC_TIMEOUT));
    // R5: exactly one outcome under the strobe
    a_r5_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> ($countones({accept_o, reject_o, timeout_o}) == 1));
    // R6: outcome held until acknowledged
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && !ts_ack_i) |=> (strobe_o && $stable({accept_o, reject_o, timeout_o})));
    // R6: strobe released once acknowledged
    a_r6_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && ts_ack_i) |=> !strobe_o);
    // R6: no rearm while acknowledge is still high
    a_r6_wait_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_RELEASE && ts_ack_i) |=> (seq_q.state == ST_RELEASE));
    // R8: overrun flag is sticky
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);
endmodule

// File: rtl/l2hs_header_check.sv
module l2hs_header_check
    import l2hs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_stb_i,
    input  logic [BUF_W-1:0] hdr_buf_i,
    input  logic [BC_W-1:0]  hdr_bc_i,
    input  logic [BUF_W-1:0] exp_buf_i,
    input  logic [BC_W-1:0]  exp_bc_i,
    output logic             mismatch_o
);
    typedef struct packed {
        logic mismatch;
    } chk_t;

    chk_t chk_d, chk_q;
    logic differs;

    always_comb begin
        chk_d   = chk_q;
        differs = (hdr_buf_i != exp_buf_i) || (hdr_bc_i != exp_bc_i);
        if (hdr_stb_i && differs) begin
            chk_d.mismatch = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_q <= '0;
        end else begin
            chk_q <= chk_d;
        end
    end

    assign mismatch_o = chk_q.mismatch;

    // R7: flag stays set
    a_r7_mismatch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |=> mismatch_o);
    // R7: a differing header is always flagged
    a_r7_mismatch_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_stb_i && hdr_bc_i != exp_bc_i) |=> mismatch_o);
endmodule

// File: rtl/l2hs_readout_ram.sv
module l2hs_readout_ram
    import l2hs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_first_i,
    input  logic [BUF_W-1:0]  wr_buf_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [BUF_W-1:0]  rd_buf_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [AW:0]       rd_count_o
);
    localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW:0]            idx;
        logic [NBUF-1:0][AW:0]  cnt;
    } ram_t;

    ram_t ram_d, ram_q;
    logic              mem_we;
    logic [AW-1:0]     mem_addr;
    logic [DATA_W-1:0] mem [NBUF*DEPTH];

    always_comb begin
        ram_d    = ram_q;
        mem_we   = 1'b0;
        mem_addr = '0;
        if (wr_en_i) begin
            if (wr_first_i) begin
                mem_we              = 1'b1;
                ram_d.idx           = (AW+1)'(1);
                ram_d.cnt[wr_buf_i] = (AW+1)'(1);
            end else if (ram_q.idx < DEPTH_L) begin
                mem_we              = 1'b1;
                mem_addr            = ram_q.idx[AW-1:0];
                ram_d.idx           = ram_q.idx + 1'b1;
                ram_d.cnt[wr_buf_i] = ram_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_q <= '0;
        end else begin
            ram_q <= ram_d;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem[{wr_buf_i, mem_addr}] <= wr_data_i;
        end
    end

    assign rd_data_o  = mem[{rd_buf_i, rd_addr_i}];
    assign rd_count_o = ram_q.cnt[rd_buf_i];

    for (genvar g = 0; g < NBUF; g++) begin : g_cnt_chk
        // R9: count never exceeds the slot depth
        a_r9_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
            ram_q.cnt[g] <= DEPTH_L);
        // R10: other buffers keep their count
        a_r10_others_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && wr_buf_i == BUF_W'(g)) |=> $stable(ram_q.cnt[g]));
    end
endmodule

// File: rtl/l2_decision_ctrl.sv
module l2_decision_ctrl
    import l2hs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l1a_i,
    input  logic [BUF_W-1:0]  l1a_buf_i,
    input  logic [BC_W-1:0]   l1a_bc_i,
    input  logic              dec_valid_i,
    input  logic [DATA_W-1:0] dec_data_i,
    input  logic              dec_last_i,
    input  logic [CNT_W-1:0]  delay_cfg_i,
    input  logic [CNT_W-1:0]  timeout_cfg_i,
    input  logic              ts_ack_i,
    output logic              ts_strobe_o,
    output logic              l2_accept_o,
    output logic              l2_reject_o,
    output logic              l2_timeout_o,
    output logic              mismatch_o,
    output logic              overrun_o,
    input  logic [BUF_W-1:0]  rd_buf_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [AW:0]       rd_count_o
);
    logic             wr_en;
    logic             wr_first;
    logic [BUF_W-1:0] lat_buf;
    logic [BC_W-1:0]  lat_bc;

    l2hs_sequencer #(.CNT_W(CNT_W)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .l1a_i        (l1a_i),
        .l1a_buf_i    (l1a_buf_i),
        .l1a_bc_i     (l1a_bc_i),
        .dec_valid_i  (dec_valid_i),
        .dec_accept_i (dec_data_i[HDR_DEC_BIT]),
        .dec_last_i   (dec_last_i),
        .delay_i      (delay_cfg_i),
        .timeout_i    (timeout_cfg_i),
        .ts_ack_i     (ts_ack_i),
        .strobe_o     (ts_strobe_o),
        .accept_o     (l2_accept_o),
        .reject_o     (l2_reject_o),
        .timeout_o    (l2_timeout_o),
        .overrun_o    (overrun_o),
        .wr_en_o      (wr_en),
        .wr_first_o   (wr_first),
        .lat_buf_o    (lat_buf),
        .lat_bc_o     (lat_bc)
    );

    l2hs_header_check i_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_stb_i  (wr_first),
        .hdr_buf_i  (dec_data_i[HDR_BUF_LSB +: BUF_W]),
        .hdr_bc_i   (dec_data_i[HDR_BC_LSB +: BC_W]),
        .exp_buf_i  (lat_buf),
        .exp_bc_i   (lat_bc),
        .mismatch_o (mismatch_o)
    );

    l2hs_readout_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_first_i (wr_first),
        .wr_buf_i   (lat_buf),
        .wr_data_i  (dec_data_i),
        .rd_buf_i   (rd_buf_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .rd_count_o (rd_count_o)
    );
endmodule

// File: tb/test_l2_decision_ctrl.sv
`timescale 1ns/1ps
module test_l2_decision_ctrl;
    localparam int DEPTH = 16;
    localparam int DLY   = 3;
    localparam int TMO   = 10;
    localparam int OC_ACC = 1, OC_REJ = 2, OC_TMO = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l1a_i = 1'b0;
    logic [1:0]  l1a_buf_i = '0;
    logic [7:0]  l1a_bc_i = '0;
    logic        dec_valid_i = 1'b0;
    logic [31:0] dec_data_i = '0;
    logic        dec_last_i = 1'b0;
    logic [15:0] delay_cfg_i = 16'(DLY);
    logic [15:0] timeout_cfg_i = 16'(TMO);
    logic        ts_ack_i = 1'b0;
    logic        ts_strobe_o, l2_accept_o, l2_reject_o, l2_timeout_o;
    logic        mismatch_o, overrun_o;
    logic [1:0]  rd_buf_i = '0;
    logic [3:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;
    logic [4:0]  rd_count_o;

    int checks = 0;
    int bad = 0;
    int exp_q[$];
    bit seen = 1'b0;

    always #10 clk = ~clk;

    l2_decision_ctrl i_l2_decision_ctrl (
        .clk(clk), .rst_n(rst_n), .l1a_i(l1a_i), .l1a_buf_i(l1a_buf_i),
        .l1a_bc_i(l1a_bc_i), .dec_valid_i(dec_valid_i), .dec_data_i(dec_data_i),
        .dec_last_i(dec_last_i), .delay_cfg_i(delay_cfg_i),
        .timeout_cfg_i(timeout_cfg_i), .ts_ack_i(ts_ack_i),
        .ts_strobe_o(ts_strobe_o), .l2_accept_o(l2_accept_o),
        .l2_reject_o(l2_reject_o), .l2_timeout_o(l2_timeout_o),
        .mismatch_o(mismatch_o), .overrun_o(overrun_o), .rd_buf_i(rd_buf_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .rd_count_o(rd_count_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int oc_now();
        return {29'd0, l2_timeout_o, l2_reject_o, l2_accept_o};
    endfunction

    function automatic logic [31:0] hdr(input bit acc, input logic [1:0] b, input logic [7:0] c);
        return {acc, 15'd0, c, 6'd0, b};
    endfunction

    function automatic logic [31:0] word(input logic [31:0] h, input int seed, input int i);
        return (i == 0) ? h : 32'(seed * 256 + i);
    endfunction

    // scoreboard monitor: judge each outcome on the strobe rise
    always @(negedge clk) begin
        if (rst_n && ts_strobe_o && !seen) begin
            seen = 1'b1;
            if (exp_q.size() == 0) begin
                chk("R5 unexpected outcome", oc_now(), 0);
            end else begin
                chk("R3/R4 outcome", oc_now(), exp_q.pop_front());
            end
            chk("R5 one outcome", $countones({l2_timeout_o, l2_reject_o, l2_accept_o}), 1);
        end
        if (!ts_strobe_o) seen = 1'b0;
    end

    task automatic send_l1a(input logic [1:0] b, input logic [7:0] c);
        @(negedge clk);
        l1a_i = 1'b1; l1a_buf_i = b; l1a_bc_i = c;
        @(negedge clk);
        l1a_i = 1'b0;
    endtask

    task automatic send_words(input int n, input logic [31:0] h, input int seed);
        for (int i = 0; i < n; i++) begin
            dec_valid_i = 1'b1;
            dec_data_i  = word(h, seed, i);
            dec_last_i  = (i == n - 1);
            @(negedge clk);
        end
        dec_valid_i = 1'b0;
        dec_last_i  = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!ts_strobe_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic handshake();
        int oc = oc_now();
        repeat (3) begin
            @(negedge clk);
            chk("R6 strobe held", ts_strobe_o, 1);
            chk("R6 outcome stable", oc_now(), oc);
        end
        ts_ack_i = 1'b1;
        @(negedge clk);
        chk("R6 strobe dropped", ts_strobe_o, 0);
        chk("R5 outcome cleared", oc_now(), 0);
        @(negedge clk);
        chk("R6 stays low with ack high", ts_strobe_o, 0);
        ts_ack_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] b, input int a, output logic [31:0] d, output int c);
        rd_buf_i = b; rd_addr_i = 4'(a);
        #1;
        d = rd_data_o; c = int'(rd_count_o);
    endtask

    initial begin
        #(20ns * 100000);
        chk("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int n, c;
        logic [31:0] d, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 strobe", ts_strobe_o, 0);
        chk("R1 outcomes", oc_now(), 0);
        chk("R1 mismatch", mismatch_o, 0);
        chk("R1 overrun", overrun_o, 0);
        for (int b = 0; b < 4; b++) begin
            rd(2'(b), 0, d, c);
            chk("R1 count", c, 0);
        end

        // R2 decision words while idle are ignored
        send_words(3, hdr(1, 2'd0, 8'h01), 9);
        repeat (TMO + 5) begin
            @(negedge clk);
            chk("R2 no strobe when idle", ts_strobe_o, 0);
        end
        rd(2'd0, 0, d, c);
        chk("R2 nothing written", c, 0);

        // R3 accept with delay, 3 words into buffer 1
        h = hdr(1, 2'd1, 8'h21);
        exp_q.push_back(OC_ACC);
        send_l1a(2'd1, 8'h21);
        send_words(3, h, 1);
        measure(n);
        chk("R3 accept delay", n, DLY + 1);
        handshake();
        rd(2'd1, 0, d, c);
        chk("R9 count buffer 1", c, 3);
        chk("R9 header word", d, h);
        rd(2'd1, 2, d, c);
        chk("R9 third word", d, word(h, 1, 2));
        chk("R7 no mismatch", mismatch_o, 0);

        // R3 reject, zero delay, single word into buffer 2
        delay_cfg_i = 16'd0;
        h = hdr(0, 2'd2, 8'h05);
        exp_q.push_back(OC_REJ);
        send_l1a(2'd2, 8'h05);
        send_words(1, h, 2);
        measure(n);
        chk("R3 zero delay", n, 1);
        handshake();
        rd(2'd2, 0, d, c);
        chk("R10 count buffer 2", c, 1);
        rd(2'd1, 0, d, c);
        chk("R10 buffer 1 kept", c, 3);
        delay_cfg_i = 16'(DLY);

        // R4 timeout without header
        exp_q.push_back(OC_TMO);
        send_l1a(2'd3, 8'h30);
        measure(n);
        chk("R4 timeout delay", n, TMO + 1);
        handshake();
        rd(2'd3, 0, d, c);
        chk("R4 nothing written", c, 0);

        // R4 header arrives in the very cycle of expiry
        h = hdr(1, 2'd0, 8'h07);
        exp_q.push_back(OC_ACC);
        send_l1a(2'd0, 8'h07);
        repeat (TMO) @(negedge clk);
        chk("R4 no early timeout", ts_strobe_o, 0);
        send_words(1, h, 3);
        measure(n);
        chk("R4 header wins delay", n, DLY + 1);
        handshake();
        rd(2'd0, 0, d, c);
        chk("R4 header written", c, 1);

        // R9 overflow: DEPTH+3 words into buffer 1
        h = hdr(1, 2'd1, 8'h44);
        exp_q.push_back(OC_ACC);
        send_l1a(2'd1, 8'h44);
        send_words(DEPTH + 3, h, 4);
        measure(n);
        chk("R3 delay after long packet", n, DLY + 1);
        handshake();
        rd(2'd1, DEPTH - 1, d, c);
        chk("R9 saturated count", c, DEPTH);
        chk("R9 last kept word", d, word(h, 4, DEPTH - 1));
        rd(2'd1, 0, d, c);
        chk("R10 new header in buffer 1", d, h);
        rd(2'd2, 0, d, c);
        chk("R10 buffer 2 kept", c, 1);
        chk("R8 no overrun yet", overrun_o, 0);

        // R8 second accept while waiting
        h = hdr(1, 2'd0, 8'h10);
        exp_q.push_back(OC_ACC);
        send_l1a(2'd0, 8'h10);
        send_l1a(2'd3, 8'h99);
        chk("R8 overrun set", overrun_o, 1);
        send_words(1, h, 5);
        measure(n);
        chk("R8 event completes", n, DLY + 1);
        handshake();
        chk("R8 first accept kept", mismatch_o, 0);
        repeat (TMO + 5) begin
            @(negedge clk);
            chk("R8 dropped accept silent", ts_strobe_o, 0);
        end
        chk("R8 overrun sticky", overrun_o, 1);

        // R7 mismatch still forwarded
        h = hdr(0, 2'd2, 8'h34);
        exp_q.push_back(OC_REJ);
        send_l1a(2'd2, 8'h33);
        send_words(1, h, 6);
        chk("R7 mismatch set", mismatch_o, 1);
        measure(n);
        chk("R7 forwarded", n, DLY + 1);
        handshake();
        chk("R7 mismatch sticky", mismatch_o, 1);
        rd(2'd2, 0, d, c);
        chk("R9 mismatch packet written", d, h);

        chk("R5 all outcomes seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule